// File: doc/BRIEF.md
# Streaming Flash Program Sequencer

This block sits between a host bus and a word-addressed NOR-style flash array and sequences the writes that program it. The host writes command words and data words to a single write port. Reads on the same port return either array contents or an 8-bit status word, depending on the current mode. The array side has an address, a write-data word, a write-enable and a read-data return. A programming write can only clear bits (new = old AND data), so the sequencer checks each word after pulsing it.

Two programming modes are offered. In word mode every word takes a command write and then an address/data write. The sequencer then issues program pulses and a verify read, retrying up to a limit. Streaming mode is opened by one command write whose address gives the start location. Each later data write programs the next consecutive location of the same block, with no address from the host. The sequencer advances the location itself, verifies each word, and closes the stream when the host writes outside the block. The host only polls the ready bit between data words.

States: `ST_READ` (array reads), `ST_STATUS` (status reads), `ST_WORD_ARM` (waiting for the address/data write), `ST_STREAM` (stream open, waiting for data), `ST_PULSE` (array write-enable held), `ST_VERIFY` (one compare read), `ST_STREAM_END` (block filled). Transitions:
- From `ST_READ` and `ST_STATUS`: FFh goes to `ST_READ`, 70h goes to `ST_STATUS`, 40h or 10h goes to `ST_WORD_ARM`, 30h goes to `ST_STREAM`.
- Any write in `ST_WORD_ARM`, and any in-block write in `ST_STREAM`, goes to `ST_PULSE`.
- `ST_PULSE` goes to `ST_VERIFY` after the last pulse cycle.
- `ST_VERIFY` goes back to `ST_PULSE` on a mismatch with retries left. A good word mode compare goes to `ST_STATUS`. A good stream compare goes to `ST_STREAM`, or to `ST_STREAM_END` on the last word of the block. A final failure goes to `ST_STATUS`.
- An out-of-block write in `ST_STREAM` or `ST_STREAM_END` goes to `ST_READ`.

Top module: `sfps_top`

## Requirements
- R1: After reset, reads return array data at the bus address. After a 70h command the status word reads 0x80: bit 7 ready set, bit 4 program error, bit 3 sequence error and bit 1 busy violation all clear.
- R2: While ready, command 70h (low byte of the write data) selects status reads and FFh selects array reads, from either read mode.
- R3: Command 40h, and equally 10h, arms word programming. The next write programs its data at its own address. On success, reads return status 0x80 and the array holds the data.
- R4: Each program pulse holds the array write-enable for PULSE_CYC consecutive cycles (default 8). One verify-read cycle with write-enable low follows. Ready (bit 7) reads 0 throughout.
- R5: When the verify read differs from the data, the pulse is repeated, up to MAX_TRY pulses in total (default 4). If the last verify also fails, status bit 4 is set and the block returns to status reads.
- R6: Command 30h opens a stream at the command's address. Each later data write whose address lies in the same block (same upper address bits above BLK_W) programs the next consecutive location, whatever its own low address bits.
- R7: In streaming mode, a write whose address lies outside the stream's block is not programmed. It closes the stream and returns the block to array reads.
- R8: Once the last location of the block has been programmed, a further in-block data write is not programmed and sets status bit 3. An out-of-block write then returns to array reads.
- R9: A write arriving while ready is 0 is ignored (no array location changes and the word in progress is kept) and sets status bit 1.
- R10: Status bits 4, 3 and 1 are sticky until a 40h, 10h or 30h command is accepted, which clears them. Unknown command codes change nothing.
- R11: When a streamed word fails its final verify, status bit 4 is set, the stream ends, and the block returns to status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | AW | Host word address |
| bus_wdata | input | DW | Host write data; low byte is the command code |
| bus_rdata | output | DW | Array data or zero-extended status word |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW | Array program data |
| arr_we | output | 1 | Array program pulse enable |
| arr_rdata | input | DW | Array read data (combinational) |

## Verification
On every cycle, the embedded properties check that:
- each fall of the array write-enable lands in the verify state;
- the pulse counter stays inside its window;
- an auto-increment never leaves the current block;
- the program-error flag rises only out of the last allowed verify;
- a write made while busy raises the busy flag and leaves the pending data untouched.

Retry counting, the stream's address sequence and the exact array contents depend on the contents of the array model, so only the bench's scenarios show them. The same holds for closing a stream by address, the sequence-error case at a filled block, and the clearing of sticky flags.

// File: rtl/sfps_pkg.sv
package sfps_pkg;
    typedef enum logic [2:0] {
        ST_READ,
        ST_STATUS,
        ST_WORD_ARM,
        ST_STREAM,
        ST_PULSE,
        ST_VERIFY,
        ST_STREAM_END
    } sfps_state_e;

    localparam logic [7:0] CMD_WORD     = 8'h40;
    localparam logic [7:0] CMD_WORD_ALT = 8'h10;
    localparam logic [7:0] CMD_STREAM   = 8'h30;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_ARRAY    = 8'hFF;

    localparam int SB_READY = 7;
    localparam int SB_PERR  = 4;
    localparam int SB_SERR  = 3;
    localparam int SB_BUSY  = 1;
endpackage

// File: rtl/sfps_pulse_timer.sv
module sfps_pulse_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == CW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run && !done)
            cnt_q <= cnt_q + CW'(1);
        else
            cnt_q <= '0;
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < CYC); // R4
endmodule

// File: rtl/sfps_addr_gen.sv
module sfps_addr_gen #(
    parameter int AW    = 8,
    parameter int BLK_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] addr_q;

    assign addr = addr_q;
    assign last = &addr_q[BLK_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= load_addr;
        else if (inc)
            addr_q <= addr_q + AW'(1);
    end

    AST_STAY_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> addr_q[AW-1:BLK_W] == $past(addr_q[AW-1:BLK_W])); // R6
endmodule

// File: rtl/sfps_top.sv
module sfps_top
    import sfps_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int BLK_W     = 3,
    parameter int PULSE_CYC = 8,
    parameter int MAX_TRY   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_we,
    input  logic [DW-1:0] arr_rdata
);
    localparam int TW = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;

    sfps_state_e   state_q, state_d;
    logic          stream_q, stream_d;
    logic [TW-1:0] tries_q, tries_d;
    logic [DW-1:0] data_q;
    logic          perr_q, serr_q, busy_q;

    logic          gen_load, gen_inc, cap, clr, set_perr, set_serr, set_busy;
    logic [AW-1:0] cur_addr;
    logic          at_last, pulse_done, ready, same_blk, verify_ok;
    logic [7:0]    cmd, status;

    sfps_addr_gen #(.AW(AW), .BLK_W(BLK_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .load_addr(bus_addr),
        .inc(gen_inc), .addr(cur_addr), .last(at_last)
    );

    sfps_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_PULSE), .done(pulse_done)
    );

    assign cmd       = bus_wdata[7:0];
    assign ready     = !(state_q == ST_PULSE || state_q == ST_VERIFY);
    assign same_blk  = bus_addr[AW-1:BLK_W] == cur_addr[AW-1:BLK_W];
    assign verify_ok = arr_rdata == data_q;
    assign status    = {ready, 2'b00, perr_q, serr_q, 1'b0, busy_q, 1'b0};

    always_comb begin
        state_d  = state_q;
        stream_d = stream_q;
        tries_d  = tries_q;
        gen_load = 1'b0;
        gen_inc  = 1'b0;
        cap      = 1'b0;
        clr      = 1'b0;
        set_perr = 1'b0;
        set_serr = 1'b0;
        set_busy = 1'b0;
        unique case (state_q)
            ST_READ, ST_STATUS: begin
                if (bus_wr) begin
                    case (cmd)
                        CMD_ARRAY:  state_d = ST_READ;
                        CMD_STATUS: state_d = ST_STATUS;
                        CMD_WORD, CMD_WORD_ALT: begin
                            state_d = ST_WORD_ARM;
                            clr     = 1'b1;
                        end
                        CMD_STREAM: begin
                            state_d  = ST_STREAM;
                            clr      = 1'b1;
                            gen_load = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WORD_ARM: begin
                if (bus_wr) begin
                    gen_load = 1'b1;
                    cap      = 1'b1;
                    stream_d = 1'b0;
                    tries_d  = '0;
                    state_d  = ST_PULSE;
                end
            end
            ST_STREAM: begin
                if (bus_wr) begin
                    if (same_blk) begin
                        cap      = 1'b1;
                        stream_d = 1'b1;
                        tries_d  = '0;
                        state_d  = ST_PULSE;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_PULSE: begin
                set_busy = bus_wr;
                if (pulse_done)
                    state_d = ST_VERIFY;
            end
            ST_VERIFY: begin
                set_busy = bus_wr;
                if (verify_ok) begin
                    if (!stream_q)
                        state_d = ST_STATUS;
                    else if (at_last)
                        state_d = ST_STREAM_END;
                    else begin
                        gen_inc = 1'b1;
                        state_d = ST_STREAM;
                    end
                end else if (tries_q == TW'(MAX_TRY - 1)) begin
                    set_perr = 1'b1;
                    state_d  = ST_STATUS;
                end else begin
                    tries_d = tries_q + TW'(1);
                    state_d = ST_PULSE;
                end
            end
            ST_STREAM_END: begin
                if (bus_wr) begin
                    if (same_blk)
                        set_serr = 1'b1;
                    else
                        state_d = ST_READ;
                end
            end
            default: state_d = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_READ;
            stream_q <= 1'b0;
            tries_q  <= '0;
            data_q   <= '0;
            perr_q   <= 1'b0;
            serr_q   <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            stream_q <= stream_d;
            tries_q  <= tries_d;
            if (cap)
                data_q <= bus_wdata;
            perr_q <= clr ? 1'b0 : (perr_q | set_perr);
            serr_q <= clr ? 1'b0 : (serr_q | set_serr);
            busy_q <= clr ? 1'b0 : (busy_q | set_busy);
        end
    end

    always_comb begin
        arr_we    = state_q == ST_PULSE;
        arr_wdata = data_q;
        arr_addr  = (state_q == ST_READ) ? bus_addr : cur_addr;
        bus_rdata = (state_q == ST_READ) ? arr_rdata : DW'(status);
    end

    AST_VERIFY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_we) |-> state_q == ST_VERIFY); // R4
    AST_PERR_ON_LAST_TRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_q) |-> ($past(state_q) == ST_VERIFY && $past(tries_q) == TW'(MAX_TRY - 1))); // R5
    AST_BUSY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ready) |=> bus_rdata[SB_BUSY]); // R9
    AST_BUSY_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ready) |=> $stable(arr_wdata)); // R9
endmodule

// File: tb/sfps_top_test.sv
module sfps_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  arr_addr;
    logic [15:0] arr_wdata;
    logic        arr_we;
    logic [15:0] arr_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int we_cyc = 0;
    int we_rise = 0;
    logic we_prev = 1'b0;
    logic [15:0] mem [256];

    always #10 clk = ~clk;

    sfps_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_rdata(arr_rdata)
    );

    function automatic logic [15:0] stuck(input logic [7:0] a);
        return (a == 8'h50) ? 16'h0001 : 16'h0000;
    endfunction

    assign arr_rdata = mem[arr_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'hFFFF;
        end else if (arr_we) begin
            mem[arr_addr] <= (mem[arr_addr] & arr_wdata) | stuck(arr_addr);
        end
        we_prev <= arr_we;
        if (arr_we) we_cyc <= we_cyc + 1;
        if (arr_we && !we_prev) we_rise <= we_rise + 1;
    end

    // {cmd, addr, data, expected}
    localparam logic [47:0] VEC [6] = '{
        48'h40_01_1234_1234,
        48'h10_02_8001_8001,
        48'h40_03_0000_0000,
        48'h10_08_FFFE_FFFE,
        48'h40_09_7F7F_7F7F,
        48'h10_0F_A5C3_A5C3
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (bus_rdata[7]) break;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int w0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(8'h10, v);  chk("R1 array read after reset", v, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rd(8'h00, v);  chk("R1 R2 reset status", v, 16'h0080);

        foreach (VEC[k]) begin
            w0 = we_cyc; r0 = we_rise;
            wr(VEC[k][39:32], {8'h00, VEC[k][47:40]});
            wr(VEC[k][39:32], VEC[k][31:16]);
            rd(VEC[k][39:32], v);  chk("R4 ready low while programming", v & 16'h0080, 16'h0000);
            chk("R4 write-enable high in pulse", {15'b0, arr_we}, 16'h0001);
            wait_ready();
            rd(8'h00, v);  chk("R3 status after word program", v, 16'h0080);
            chk("R4 pulse length", 16'(we_cyc - w0), 16'd8);
            chk("R4 single pulse", 16'(we_rise - r0), 16'd1);
            wr(8'h00, 16'h00FF);
            rd(VEC[k][39:32], v);  chk("R3 R2 array holds word", v, VEC[k][15:0]);
        end

        // R9: write while busy
        wr(8'h11, 16'h0040);
        wr(8'h11, 16'h5A5A);
        wr(8'h12, 16'h0000);
        wait_ready();
        rd(8'h00, v);  chk("R9 busy flag", v, 16'h0082);
        wr(8'h00, 16'h00FF);
        rd(8'h11, v);  chk("R9 pending word kept", v, 16'h5A5A);
        rd(8'h12, v);  chk("R9 busy write ignored", v, 16'hFFFF);

        // R10: new command clears flags
        wr(8'h13, 16'h0010);
        wr(8'h13, 16'h1111);
        wait_ready();
        rd(8'h00, v);  chk("R10 flags cleared", v, 16'h0080);

        // R5: verify failure with retries
        w0 = we_cyc; r0 = we_rise;
        wr(8'h50, 16'h0040);
        wr(8'h50, 16'h1234);
        wait_ready();
        rd(8'h00, v);  chk("R5 program error", v, 16'h0090);
        chk("R5 pulse count", 16'(we_rise - r0), 16'd4);
        chk("R5 total pulse cycles", 16'(we_cyc - w0), 16'd32);
        wr(8'h00, 16'h0077);
        rd(8'h00, v);  chk("R10 unknown command ignored", v, 16'h0090);
        wr(8'h00, 16'h00FF);
        rd(8'h50, v);  chk("R5 array after failure", v, 16'h1235);

        // R6/R7: stream into block 0x20..0x27
        wr(8'h20, 16'h0030);
        wr(8'h25, 16'hC001); wait_ready();
        rd(8'h00, v);  chk("R6 stream ready", v, 16'h0080);
        wr(8'h20, 16'hC002); wait_ready();
        wr(8'h27, 16'hC003); wait_ready();
        wr(8'h40, 16'h0BAD);
        rd(8'h20, v);  chk("R6 stream word 0", v, 16'hC001);
        rd(8'h21, v);  chk("R6 stream word 1", v, 16'hC002);
        rd(8'h22, v);  chk("R6 stream word 2", v, 16'hC003);
        rd(8'h23, v);  chk("R6 next location untouched", v, 16'hFFFF);
        rd(8'h25, v);  chk("R6 host low address ignored", v, 16'hFFFF);
        rd(8'h40, v);  chk("R7 exit write not programmed", v, 16'hFFFF);

        // R8: fill block 0x30..0x37 from 0x36
        wr(8'h36, 16'h0030);
        wr(8'h30, 16'hA001); wait_ready();
        wr(8'h30, 16'hA002); wait_ready();
        wr(8'h31, 16'hA003);
        rd(8'h00, v);  chk("R8 sequence error", v, 16'h0088);
        wr(8'h90, 16'h0000);
        rd(8'h36, v);  chk("R8 word at 0x36", v, 16'hA001);
        rd(8'h37, v);  chk("R8 word at 0x37", v, 16'hA002);
        rd(8'h30, v);  chk("R8 no wrap to 0x30", v, 16'hFFFF);
        rd(8'h31, v);  chk("R8 extra data not programmed", v, 16'hFFFF);
        rd(8'h90, v);  chk("R7 R8 exit not programmed", v, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rd(8'h00, v);  chk("R10 sticky sequence error", v, 16'h0088);

        // R11: streamed word fails verify
        wr(8'h50, 16'h0030);
        wr(8'h50, 16'h2222);
        wait_ready();
        rd(8'h00, v);  chk("R11 stream program error", v, 16'h0090);
        wr(8'h51, 16'h0077);
        rd(8'h51, v);  chk("R11 stream closed to status", v, 16'h0090);
        wr(8'h00, 16'h00FF);
        rd(8'h51, v);  chk("R11 no later location programmed", v, 16'hFFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule